// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Line Steering

This controller gathers 32 level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). A per-source routing bit decides which line a source drives. Software turns sources on with a write-one-to-set enable register and off with a separate write-one-to-clear register. It can also raise any source itself through a matching pair of set and clear registers.

For the normal line, each source carries a 4-bit priority level and a 32-bit vector word. A 16-bit level mask decides which priority levels may reach the IRQ line. Among the pending, unmasked IRQ sources the controller picks a winner and shows that source's vector word on a dedicated output. The handler can then branch without scanning status. A protection bit can lock every register write to privileged bus accesses.

The register bus is a plain single-cycle port. It takes a word address (byte offset divided by four), a write strobe, write data and a privilege attribute. Read data is combinational on the same cycle. The three processor-facing outputs are registered.

Top module: `intc_vec`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `fiq_o` and `vec_addr_o` are 0.
- R2: The raw status word at byte offset 0x08 equals the source inputs ORed with the software request bits.
- R3: A routing bit of 0 in the select register (0x0C) sends its source to IRQ, and 1 sends it to FIQ. IRQ status (0x00) is raw AND enable AND NOT select. FIQ status (0x04) is raw AND enable AND select. `fiq_o` is the OR of FIQ status and ignores the level mask.
- R4: Writing the enable register (0x10) sets each bit written as 1 and leaves bits written as 0 unchanged. Writing 1s to the enable-clear register (0x14) clears those enable bits. Reads of 0x14 and 0x1C return 0.
- R5: Writing 1s to the software register (0x18) sets software request bits. Writing 1s to 0x1C clears them, and 0 bits leave them unchanged.
- R6: When bit 0 of the protection register (0x20) is 1, writes with `bus_priv_i` low change no register, including the protection register itself. Privileged writes still take effect.
- R7: Bit L of the level mask (0x24, bits 15:0) set to 0 blocks every IRQ source whose priority level is L from `irq_o` and from vector selection.
- R8: The vector word of source i is read and written at byte offset 0x100+4i. Its priority level is at 0x200+4i, bits 3:0, and the upper bits read 0.
- R9: `vec_addr_o` shows the vector word of the pending unmasked IRQ source with the numerically lowest priority level, where 0 is most urgent. Ties go to the lowest source number. The output is 0 when no such source exists, and `irq_o` is 1 exactly when one exists.
- R10: `irq_o`, `fiq_o` and `vec_addr_o` are registered. They reflect source inputs and register contents one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_priv_i | input | 1 | Access is privileged |
| bus_waddr_i | input | 10 | Word address (byte offset / 4) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| src_i | input | 32 | Level-sensitive hardware sources |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| vec_addr_o | output | 32 | Vector word of the winning IRQ source |

## Verification
A register write lands on the clock edge where it is strobed, so a read issued on the next cycle already shows it. The processor-facing outputs trail by one more edge, because the arbiter result passes through an output register. The bench therefore samples the outputs at the falling edge that follows the edge after a write or a source change. The R10 check also samples one nanosecond after changing a source, to confirm the outputs have not moved yet.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned DATA_W = 32;

  // byte offsets of the control/status words
  localparam int unsigned OFS_IRQ_STAT = 'h00;
  localparam int unsigned OFS_FIQ_STAT = 'h04;
  localparam int unsigned OFS_RAW      = 'h08;
  localparam int unsigned OFS_ROUTE    = 'h0C;
  localparam int unsigned OFS_EN_SET   = 'h10;
  localparam int unsigned OFS_EN_CLR   = 'h14;
  localparam int unsigned OFS_SW_SET   = 'h18;
  localparam int unsigned OFS_SW_CLR   = 'h1C;
  localparam int unsigned OFS_LOCK     = 'h20;
  localparam int unsigned OFS_LVL_MASK = 'h24;
  localparam int unsigned OFS_VEC_BASE = 'h100;
  localparam int unsigned OFS_LVL_BASE = 'h200;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign srst_no = stage1_q;
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned WA_W  = ADDR_W - 2,
  localparam int unsigned NLVL  = 1 << LVL_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_sel_i,
  input  logic                           bus_wr_i,
  input  logic                           bus_priv_i,
  input  logic [WA_W-1:0]                bus_waddr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  input  logic [NSRC-1:0]                src_i,
  output logic [NSRC-1:0]                en_o,
  output logic [NSRC-1:0]                route_o,
  output logic [NSRC-1:0]                sw_o,
  output logic                           lock_o,
  output logic [NLVL-1:0]                lvl_mask_o,
  output logic [NSRC-1:0]                irq_stat_o,
  output logic [NSRC-1:0]                fiq_stat_o,
  output logic [NSRC-1:0][LVL_W-1:0]     lvl_o,
  output logic [NSRC-1:0][DATA_W-1:0]    vec_o
);
  localparam logic [WA_W-1:0] W_IRQ  = WA_W'(OFS_IRQ_STAT >> 2);
  localparam logic [WA_W-1:0] W_FIQ  = WA_W'(OFS_FIQ_STAT >> 2);
  localparam logic [WA_W-1:0] W_RAW  = WA_W'(OFS_RAW >> 2);
  localparam logic [WA_W-1:0] W_RTE  = WA_W'(OFS_ROUTE >> 2);
  localparam logic [WA_W-1:0] W_ENS  = WA_W'(OFS_EN_SET >> 2);
  localparam logic [WA_W-1:0] W_ENC  = WA_W'(OFS_EN_CLR >> 2);
  localparam logic [WA_W-1:0] W_SWS  = WA_W'(OFS_SW_SET >> 2);
  localparam logic [WA_W-1:0] W_SWC  = WA_W'(OFS_SW_CLR >> 2);
  localparam logic [WA_W-1:0] W_LCK  = WA_W'(OFS_LOCK >> 2);
  localparam logic [WA_W-1:0] W_MSK  = WA_W'(OFS_LVL_MASK >> 2);
  localparam int unsigned     W_VEC0 = OFS_VEC_BASE >> 2;
  localparam int unsigned     W_LVL0 = OFS_LVL_BASE >> 2;

  logic [NSRC-1:0]  en_q, en_d;
  logic [NSRC-1:0]  route_q, route_d;
  logic [NSRC-1:0]  sw_q, sw_d;
  logic             lock_q, lock_d;
  logic [NLVL-1:0]  mask_q, mask_d;
  logic [NSRC-1:0]  raw;
  logic             wr_ok;
  logic             rd_ok;
  logic [NSRC-1:0]  vec_hit, lvl_hit;

  assign wr_ok = bus_sel_i && bus_wr_i && (!lock_q || bus_priv_i);
  assign rd_ok = bus_sel_i && !bus_wr_i;

  // status composition
  assign raw        = src_i | sw_q;
  assign irq_stat_o = raw & en_q & ~route_q;
  assign fiq_stat_o = raw & en_q & route_q;

  // control next state
  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    sw_d    = sw_q;
    lock_d  = lock_q;
    mask_d  = mask_q;
    if (wr_ok) begin
      unique case (bus_waddr_i)
        W_RTE:   route_d = bus_wdata_i[NSRC-1:0];
        W_ENS:   en_d    = en_q | bus_wdata_i[NSRC-1:0];
        W_ENC:   en_d    = en_q & ~bus_wdata_i[NSRC-1:0];
        W_SWS:   sw_d    = sw_q | bus_wdata_i[NSRC-1:0];
        W_SWC:   sw_d    = sw_q & ~bus_wdata_i[NSRC-1:0];
        W_LCK:   lock_d  = bus_wdata_i[0];
        W_MSK:   mask_d  = bus_wdata_i[NLVL-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
      sw_q    <= '0;
      lock_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      en_q    <= en_d;
      route_q <= route_d;
      sw_q    <= sw_d;
      lock_q  <= lock_d;
      mask_q  <= mask_d;
    end
  end

  // per-source vector and level storage
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [DATA_W-1:0] vec_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              vec_we, lvl_we;

    assign vec_hit[i] = (bus_waddr_i == WA_W'(W_VEC0 + i));
    assign lvl_hit[i] = (bus_waddr_i == WA_W'(W_LVL0 + i));
    assign vec_we     = wr_ok && vec_hit[i];
    assign lvl_we     = wr_ok && lvl_hit[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q <= '0;
        lvl_q <= '0;
      end else begin
        if (vec_we) vec_q <= bus_wdata_i;
        if (lvl_we) lvl_q <= bus_wdata_i[LVL_W-1:0];
      end
    end

    assign vec_o[i] = vec_q;
    assign lvl_o[i] = lvl_q;
  end

  // read path
  always_comb begin
    bus_rdata_o = '0;
    if (rd_ok) begin
      unique case (bus_waddr_i)
        W_IRQ:   bus_rdata_o = DATA_W'(irq_stat_o);
        W_FIQ:   bus_rdata_o = DATA_W'(fiq_stat_o);
        W_RAW:   bus_rdata_o = DATA_W'(raw);
        W_RTE:   bus_rdata_o = DATA_W'(route_q);
        W_ENS:   bus_rdata_o = DATA_W'(en_q);
        W_SWS:   bus_rdata_o = DATA_W'(sw_q);
        W_LCK:   bus_rdata_o = DATA_W'(lock_q);
        W_MSK:   bus_rdata_o = DATA_W'(mask_q);
        default: begin
          for (int i = 0; i < NSRC; i++) begin
            if (vec_hit[i]) bus_rdata_o = vec_o[i];
            if (lvl_hit[i]) bus_rdata_o = DATA_W'(lvl_o[i]);
          end
        end
      endcase
    end
  end

  assign en_o       = en_q;
  assign route_o    = route_q;
  assign sw_o       = sw_q;
  assign lock_o     = lock_q;
  assign lvl_mask_o = mask_q;
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned NLVL = 1 << LVL_W
) (
  input  logic [NSRC-1:0]              pend_i,
  input  logic [NSRC-1:0][LVL_W-1:0]   lvl_i,
  input  logic [NLVL-1:0]              lvl_mask_i,
  input  logic [NSRC-1:0][DATA_W-1:0]  vec_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            vec_o
);
  logic [LVL_W-1:0] best_lvl;

  // scan downward so that an equal level at a lower index replaces the holder
  always_comb begin
    hit_o    = 1'b0;
    best_lvl = '1;
    vec_o    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i] && lvl_mask_i[lvl_i[i]] &&
          (!hit_o || (lvl_i[i] <= best_lvl))) begin
        hit_o    = 1'b1;
        best_lvl = lvl_i[i];
        vec_o    = vec_i[i];
      end
    end
  end
endmodule

// File: rtl/intc_vec.sv
module intc_vec
  import intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned WA_W  = ADDR_W - 2,
  localparam int unsigned NLVL  = 1 << LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_priv_i,
  input  logic [WA_W-1:0]   bus_waddr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [31:0]       vec_addr_o
);
  logic                          rst_sync_n;
  logic [NSRC-1:0]               en_w, route_w, sw_w;
  logic                          lock_w;
  logic [NLVL-1:0]               mask_w;
  logic [NSRC-1:0]               irq_stat_w, fiq_stat_w;
  logic [NSRC-1:0][LVL_W-1:0]    lvl_w;
  logic [NSRC-1:0][DATA_W-1:0]   vec_w;
  logic                          pick_hit;
  logic [DATA_W-1:0]             pick_vec;
  logic                          irq_q, irq_d;
  logic                          fiq_q, fiq_d;
  logic [DATA_W-1:0]             vaddr_q, vaddr_d;

  intc_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_sync_n)
  );

  intc_regfile #(.NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_priv_i  (bus_priv_i),
    .bus_waddr_i (bus_waddr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .src_i       (src_i),
    .en_o        (en_w),
    .route_o     (route_w),
    .sw_o        (sw_w),
    .lock_o      (lock_w),
    .lvl_mask_o  (mask_w),
    .irq_stat_o  (irq_stat_w),
    .fiq_stat_o  (fiq_stat_w),
    .lvl_o       (lvl_w),
    .vec_o       (vec_w)
  );

  intc_prio_pick #(.NSRC(NSRC), .LVL_W(LVL_W)) u_pick (
    .pend_i     (irq_stat_w),
    .lvl_i      (lvl_w),
    .lvl_mask_i (mask_w),
    .vec_i      (vec_w),
    .hit_o      (pick_hit),
    .vec_o      (pick_vec)
  );

  always_comb begin
    irq_d   = pick_hit;
    fiq_d   = |fiq_stat_w;
    vaddr_d = pick_hit ? pick_vec : '0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      vaddr_q <= '0;
    end else begin
      irq_q   <= irq_d;
      fiq_q   <= fiq_d;
      vaddr_q <= vaddr_d;
    end
  end

  assign irq_o      = irq_q;
  assign fiq_o      = fiq_q;
  assign vec_addr_o = vaddr_q;
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk
  import intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned WA_W  = ADDR_W - 2,
  localparam int unsigned NLVL  = 1 << LVL_W
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic              bus_priv_i,
  input logic [WA_W-1:0]   bus_waddr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [NSRC-1:0]   en_w,
  input logic [NSRC-1:0]   route_w,
  input logic [NSRC-1:0]   sw_w,
  input logic              lock_w,
  input logic [NLVL-1:0]   mask_w,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [31:0]       vec_addr_o
);
  localparam logic [WA_W-1:0] W_ENS = WA_W'(OFS_EN_SET >> 2);
  localparam logic [WA_W-1:0] W_ENC = WA_W'(OFS_EN_CLR >> 2);
  localparam logic [WA_W-1:0] W_SWC = WA_W'(OFS_SW_CLR >> 2);

  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fiq_o |-> $past(|(en_w & route_w))); // R3

  AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    irq_o |-> $past(|(en_w & ~route_w))); // R3

  AST_ENSET_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_sel_i && bus_wr_i && bus_waddr_i == W_ENS && (!lock_w || bus_priv_i))
      |=> (($past(en_w) & ~en_w) == '0)); // R4

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_sel_i && !bus_wr_i && (bus_waddr_i == W_ENC || bus_waddr_i == W_SWC))
      |-> bus_rdata_o == '0); // R4

  AST_LOCK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (bus_sel_i && bus_wr_i && !bus_priv_i && lock_w)
      |=> ($stable(en_w) && $stable(route_w) && $stable(sw_w) &&
           $stable(lock_w) && $stable(mask_w))); // R6

  AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    irq_o |-> $past(|mask_w)); // R7

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !irq_o |-> vec_addr_o == '0); // R9
endmodule

bind intc_vec intc_vec_chk #(.NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_sync_n  (rst_sync_n),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_priv_i  (bus_priv_i),
  .bus_waddr_i (bus_waddr_i),
  .bus_rdata_o (bus_rdata_o),
  .en_w        (en_w),
  .route_w     (route_w),
  .sw_w        (sw_w),
  .lock_w      (lock_w),
  .mask_w      (mask_w),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .vec_addr_o  (vec_addr_o)
);

// File: tb/intc_vec_tb.sv
`timescale 1ns/1ps
module intc_vec_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_priv;
  logic [9:0]  bus_waddr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] src;
  logic        irq, fiq;
  logic [31:0] vaddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  intc_vec u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_priv_i  (bus_priv),
    .bus_waddr_i (bus_waddr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .src_i       (src),
    .irq_o       (irq),
    .fiq_o       (fiq),
    .vec_addr_o  (vaddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d, input logic priv = 1'b1);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv;
    bus_waddr = ofs[11:2]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = ofs[11:2];
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] ofs, input logic [31:0] exp);
    logic [31:0] d;
    rd(ofs, d);
    chk(req, d, exp);
  endtask

  // outputs register one edge after the write edge
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 irq stat", 12'h000, 0);
    rd_chk("R1 fiq stat", 12'h004, 0);
    rd_chk("R1 raw",      12'h008, 0);
    rd_chk("R1 route",    12'h00C, 0);
    rd_chk("R1 enable",   12'h010, 0);
    rd_chk("R1 soft",     12'h018, 0);
    rd_chk("R1 lock",     12'h020, 0);
    rd_chk("R1 mask",     12'h024, 0);
    rd_chk("R1 vec0",     12'h100, 0);
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    chk("R1 vec_addr_o", vaddr, 0);
  endtask

  task automatic t_raw();
    @(negedge clk); src = 32'h0000_00A5;
    wr(12'h018, 32'h0100_0000);
    rd_chk("R2 raw with soft", 12'h008, 32'h0100_00A5);
    rd_chk("R5 soft set",      12'h018, 32'h0100_0000);
    wr(12'h01C, 32'h0000_0000);
    rd_chk("R5 soft clr zero no effect", 12'h018, 32'h0100_0000);
    wr(12'h01C, 32'h0100_0000);
    rd_chk("R5 soft cleared",  12'h018, 0);
    rd_chk("R2 raw hw only",   12'h008, 32'h0000_00A5);
    rd_chk("R4 soft-clr reads 0", 12'h01C, 0);
  endtask

  task automatic t_route();
    @(negedge clk); src = 32'h0000_0033;
    wr(12'h010, 32'h0000_00FF);
    wr(12'h00C, 32'h0000_000F);
    settle();
    rd_chk("R3 irq stat", 12'h000, 32'h30);
    rd_chk("R3 fiq stat", 12'h004, 32'h03);
    chk("R3 fiq_o", {31'b0, fiq}, 1);
    chk("R7 irq_o masked at level 0", {31'b0, irq}, 0);
    wr(12'h010, 32'h0);
    rd_chk("R4 enable write 0 no effect", 12'h010, 32'hFF);
    wr(12'h014, 32'h0000_0002);
    rd_chk("R4 enable cleared", 12'h010, 32'hFD);
    rd_chk("R3 fiq after disable", 12'h004, 32'h01);
    rd_chk("R4 en-clr reads 0", 12'h014, 0);
  endtask

  task automatic t_vector();
    wr(12'h110, 32'h0000_1040);
    wr(12'h114, 32'h0000_1050);
    wr(12'h024, 32'h0000_0001);
    settle();
    chk("R9 irq_o level0", {31'b0, irq}, 1);
    chk("R9 tie lowest index", vaddr, 32'h1040);
    wr(12'h210, 32'h3);
    wr(12'h214, 32'h2);
    wr(12'h024, 32'h0000_FFFF);
    settle();
    chk("R9 lower level wins", vaddr, 32'h1050);
    wr(12'h024, 32'h0000_FFFB);
    settle();
    chk("R7 level 2 masked", vaddr, 32'h1040);
    wr(12'h024, 32'h0000_FFF3);
    settle();
    chk("R7 all pending masked irq", {31'b0, irq}, 0);
    chk("R9 vec zero when none", vaddr, 0);
    chk("R3 fiq ignores mask", {31'b0, fiq}, 1);
    wr(12'h210, 32'h2);
    wr(12'h024, 32'h0000_FFFF);
    settle();
    chk("R9 tie at level 2", vaddr, 32'h1040);
  endtask

  task automatic t_timing();
    @(negedge clk); src = 32'h0000_0023;
    #1 chk("R10 not yet updated", vaddr, 32'h1040);
    @(negedge clk);
    chk("R10 updated after edge", vaddr, 32'h1050);
    @(negedge clk); src = 32'h0000_0003;
    @(negedge clk);
    chk("R9 none pending irq_o", {31'b0, irq}, 0);
  endtask

  task automatic t_lock();
    wr(12'h020, 32'h1);
    wr(12'h010, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R6 unpriv enable ignored", 12'h010, 32'hFD);
    wr(12'h020, 32'h0, 1'b0);
    rd_chk("R6 unpriv unlock ignored", 12'h020, 32'h1);
    wr(12'h010, 32'h100, 1'b1);
    rd_chk("R6 priv write lands", 12'h010, 32'h1FD);
    wr(12'h020, 32'h0, 1'b1);
    wr(12'h014, 32'h100, 1'b0);
    rd_chk("R6 unpriv write when unlocked", 12'h010, 32'hFD);
  endtask

  task automatic t_store();
    wr(12'h17C, 32'hDEAD_BEEF);
    rd_chk("R8 vec31 readback", 12'h17C, 32'hDEAD_BEEF);
    wr(12'h27C, 32'hFFFF_FFFF);
    rd_chk("R8 level31 width", 12'h27C, 32'h0000_000F);
    rd_chk("R8 level0 untouched", 12'h200, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
    bus_waddr = '0; bus_wdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw();
    t_route();
    t_vector();
    t_timing();
    t_lock();
    t_store();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule